// File: doc/BRIEF.md
# Serial Mode Command Receiver

This block accepts 8-bit commands from a host microcontroller over three wires: an enable line, a shift clock and a data line. While the enable line is high, each rising edge of the shift clock moves one data bit into a command register, least significant bit first. All three lines and a slow reference clock of about 130 kHz are synchronized into the fast system clock domain. Edges are detected there.

When the enable line falls, the current register contents are captured as the command to run. The command takes effect only on the next rising edge of the reference clock. Some commands change level-type mode outputs: laser, focus servo, spindle size mode, sled drive and tracking servo. Others emit one-cycle strobes: reset, focus search, balance start, and start or stop of the focus and track offset adjustments.

The command register keeps its value after a command runs. A later enable pulse with no shift clocks therefore runs the same command again. The host sends the no-op code after a one-shot command to prevent this. An offset adjustment start that arrives too soon after power-on, after a reset command or after its own stop command is deferred until a hold-off counted in reference ticks has elapsed.

Top module: `ser_cmd_rx`

## Requirements
- R1: After `rstN` is released, every mode output is 0 and no strobe output pulses.
- R2: While `serEn` is high, each rising edge of `serClk` shifts `serData` in, and the first bit becomes bit 0. If more than 8 bits are sent, the last 8 bits form the command.
- R3: A captured command changes no output before the first rising edge of `refClk` that follows the fall of `serEn`. Its outputs update within a few system cycles after that edge.
- R4: Code 0x06 sets the laser and the focus servo on. Code 0x07 sets the laser off and the focus servo on. Code 0x08 sets both off.
- R5: On `spindleMode`, 0 means off, 1 means small disc and 2 means large disc. Code 0x09 selects small disc, 0x0A selects large disc and 0x0B selects off.
- R6: Code 0x0C turns the sled on and 0x0D turns it off. Code 0x10 turns the tracking servo on and 0x0F turns it off.
- R7: Code 0x01 pulses `focusSearchPulse` and code 0x0E pulses `balanceStartPulse`. Each strobe lasts exactly one system cycle.
- R8: An enable pulse with no shift clock edges runs the last command again. Code 0xFE is a no-op, so after it such a pulse has no effect.
- R9: Code 0x00 clears every mode output and both adjust-active outputs, and pulses `resetPulse`.
- R10: A code not listed in R4 to R9 and R11 leaves every output unchanged.
- R11: Code 0x02 starts the focus offset adjustment and 0x03 stops it. Codes 0x04 and 0x05 do the same for the track offset adjustment. A start sets the matching active output and pulses its start strobe. A stop clears the active output and pulses its stop strobe.
- R12: After power-on, after code 0x00, or after the matching stop code, an adjustment start is deferred until HOLD_TICKS reference rising edges have passed since that event. It then takes effect by itself.
- R13: `serClk` edges while `serEn` is low do not alter the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| serEn | input | 1 | Command enable from host |
| serClk | input | 1 | Shift clock from host |
| serData | input | 1 | Serial command data, LSB first |
| refClk | input | 1 | Slow reference clock (about 130 kHz) |
| laserOn | output | 1 | Laser drive mode |
| focusServoOn | output | 1 | Focus servo mode |
| spindleMode | output | 2 | Spindle mode: 0 off, 1 small, 2 large |
| sledOn | output | 1 | Sled drive enabled |
| trackServoOn | output | 1 | Tracking servo enabled |
| focusAdjActive | output | 1 | Focus offset adjustment active |
| trackAdjActive | output | 1 | Track offset adjustment active |
| resetPulse | output | 1 | One-cycle strobe on reset command |
| focusSearchPulse | output | 1 | One-cycle strobe on focus search command |
| balanceStartPulse | output | 1 | One-cycle strobe on balance start command |
| focusAdjStartPulse | output | 1 | One-cycle strobe when focus adjustment begins |
| focusAdjStopPulse | output | 1 | One-cycle strobe on focus adjustment stop |
| trackAdjStartPulse | output | 1 | One-cycle strobe when track adjustment begins |
| trackAdjStopPulse | output | 1 | One-cycle strobe on track adjustment stop |

## Verification
The bench builds the block with an 8-bit command, two synchronizer stages and HOLD_TICKS set to 4. With that short hold-off, the deferred start after a reset command, and its release on exactly the fourth reference tick, can be observed within a handful of ticks. The real value is several hundred ticks. A ten-bit transfer exercises the keep-the-last-eight rule. Shift clocks sent with the enable low, followed by a bare enable pulse, show that the held command survives and runs again.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  typedef enum logic [1:0] {
    SPIN_OFF   = 2'd0,
    SPIN_SMALL = 2'd1,
    SPIN_LARGE = 2'd2
  } spindle_e;

  localparam logic [7:0] CODE_RESET      = 8'h00;
  localparam logic [7:0] CODE_FOCUS_SRCH = 8'h01;
  localparam logic [7:0] CODE_FADJ_START = 8'h02;
  localparam logic [7:0] CODE_FADJ_STOP  = 8'h03;
  localparam logic [7:0] CODE_TADJ_START = 8'h04;
  localparam logic [7:0] CODE_TADJ_STOP  = 8'h05;
  localparam logic [7:0] CODE_LAS1_SRV1  = 8'h06;
  localparam logic [7:0] CODE_LAS0_SRV1  = 8'h07;
  localparam logic [7:0] CODE_LAS0_SRV0  = 8'h08;
  localparam logic [7:0] CODE_SPIN_SMALL = 8'h09;
  localparam logic [7:0] CODE_SPIN_LARGE = 8'h0A;
  localparam logic [7:0] CODE_SPIN_OFF   = 8'h0B;
  localparam logic [7:0] CODE_SLED_ON    = 8'h0C;
  localparam logic [7:0] CODE_SLED_OFF   = 8'h0D;
  localparam logic [7:0] CODE_BAL_START  = 8'h0E;
  localparam logic [7:0] CODE_TRK_OFF    = 8'h0F;
  localparam logic [7:0] CODE_TRK_ON     = 8'h10;
  localparam logic [7:0] CODE_NOP        = 8'hFE;

  typedef struct packed {
    logic     rst;
    logic     focusStart;
    logic     balStart;
    logic     focAdjOn;
    logic     focAdjOff;
    logic     trkAdjOn;
    logic     trkAdjOff;
    logic     servoWr;
    logic     laserVal;
    logic     focServoVal;
    logic     spinWr;
    spindle_e spinVal;
    logic     sledWr;
    logic     sledVal;
    logic     trkWr;
    logic     trkVal;
  } cmdStrobes_t;

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] level
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign level = pipe[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("cmdrx_sync needs at least two stages");
  end
endmodule

// File: rtl/cmdrx_ctrl.sv
module cmdrx_ctrl
  import cmdrx_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serEn,
  input  logic        serClk,
  input  logic        serData,
  input  logic        refClk,
  output cmdStrobes_t strobes,
  output logic        tick
);
  localparam int N_SYNC = 4;

  logic [N_SYNC-1:0] syncLvl;
  logic enLvl, clkLvl, dataLvl, refLvl;
  logic enPrev, clkPrev, refPrev;
  logic enFall, clkRise, refRise;
  logic [CMD_W-1:0] shiftReg, heldCmd;
  logic pend, apply;

  cmdrx_sync #(.N(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({refClk, serData, serClk, serEn}),
    .level(syncLvl)
  );

  assign enLvl   = syncLvl[0];
  assign clkLvl  = syncLvl[1];
  assign dataLvl = syncLvl[2];
  assign refLvl  = syncLvl[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      enPrev  <= enLvl;
      clkPrev <= clkLvl;
      refPrev <= refLvl;
    end
  end

  assign enFall  = enPrev & ~enLvl;
  assign clkRise = clkLvl & ~clkPrev;
  assign refRise = refLvl & ~refPrev;
  assign tick    = refRise;

  // shift register, LSB first: newest bit enters at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (enLvl && clkRise) begin
      shiftReg <= {dataLvl, shiftReg[CMD_W-1:1]};
    end
  end

  // capture on enable fall, run on the next reference rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCmd <= '0;
      pend    <= 1'b0;
    end else if (enFall) begin
      heldCmd <= shiftReg;
      pend    <= 1'b1;
    end else if (pend && refRise) begin
      pend    <= 1'b0;
    end
  end

  assign apply = pend && refRise && !enFall;

  always_comb begin
    strobes = '0;
    if (apply) begin
      case (heldCmd)
        CMD_W'(CODE_RESET):      strobes.rst        = 1'b1;
        CMD_W'(CODE_FOCUS_SRCH): strobes.focusStart = 1'b1;
        CMD_W'(CODE_BAL_START):  strobes.balStart   = 1'b1;
        CMD_W'(CODE_FADJ_START): strobes.focAdjOn   = 1'b1;
        CMD_W'(CODE_FADJ_STOP):  strobes.focAdjOff  = 1'b1;
        CMD_W'(CODE_TADJ_START): strobes.trkAdjOn   = 1'b1;
        CMD_W'(CODE_TADJ_STOP):  strobes.trkAdjOff  = 1'b1;
        CMD_W'(CODE_LAS1_SRV1): begin
          strobes.servoWr     = 1'b1;
          strobes.laserVal    = 1'b1;
          strobes.focServoVal = 1'b1;
        end
        CMD_W'(CODE_LAS0_SRV1): begin
          strobes.servoWr     = 1'b1;
          strobes.focServoVal = 1'b1;
        end
        CMD_W'(CODE_LAS0_SRV0):  strobes.servoWr = 1'b1;
        CMD_W'(CODE_SPIN_SMALL): begin
          strobes.spinWr  = 1'b1;
          strobes.spinVal = SPIN_SMALL;
        end
        CMD_W'(CODE_SPIN_LARGE): begin
          strobes.spinWr  = 1'b1;
          strobes.spinVal = SPIN_LARGE;
        end
        CMD_W'(CODE_SPIN_OFF):   strobes.spinWr = 1'b1;
        CMD_W'(CODE_SLED_ON): begin
          strobes.sledWr  = 1'b1;
          strobes.sledVal = 1'b1;
        end
        CMD_W'(CODE_SLED_OFF):   strobes.sledWr = 1'b1;
        CMD_W'(CODE_TRK_ON): begin
          strobes.trkWr  = 1'b1;
          strobes.trkVal = 1'b1;
        end
        CMD_W'(CODE_TRK_OFF):    strobes.trkWr = 1'b1;
        default: ;  // no-op code and unknown codes do nothing
      endcase
    end
  end

  // R13: with the enable low the command register holds its value
  assert_idle_shift_R13: assert property (@(posedge clk) disable iff (!rstN)
    !enLvl |=> $stable(shiftReg));

  // R7: at most one action is decoded per cycle
  assert_single_action_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rst, strobes.focusStart, strobes.balStart, strobes.focAdjOn,
              strobes.focAdjOff, strobes.trkAdjOn, strobes.trkAdjOff, strobes.servoWr,
              strobes.spinWr, strobes.sledWr, strobes.trkWr}));
endmodule

// File: rtl/cmdrx_datapath.sv
module cmdrx_datapath
  import cmdrx_pkg::*;
#(
  parameter int HOLD_TICKS = 520
) (
  input  logic        clk,
  input  logic        rstN,
  input  cmdStrobes_t strobes,
  input  logic        tick,
  output logic        laserOn,
  output logic        focusServoOn,
  output spindle_e    spindleMode,
  output logic        sledOn,
  output logic        trackServoOn,
  output logic [1:0]  adjActive,
  output logic [1:0]  adjStartPulse,
  output logic [1:0]  adjStopPulse,
  output logic        resetPulse,
  output logic        focusSearchPulse,
  output logic        balanceStartPulse
);
  localparam int N_ADJ = 2;
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);

  logic [N_ADJ-1:0] startReq, stopReq;
  assign startReq = {strobes.trkAdjOn,  strobes.focAdjOn};
  assign stopReq  = {strobes.trkAdjOff, strobes.focAdjOff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laserOn           <= 1'b0;
      focusServoOn      <= 1'b0;
      spindleMode       <= SPIN_OFF;
      sledOn            <= 1'b0;
      trackServoOn      <= 1'b0;
      resetPulse        <= 1'b0;
      focusSearchPulse  <= 1'b0;
      balanceStartPulse <= 1'b0;
    end else begin
      resetPulse        <= strobes.rst;
      focusSearchPulse  <= strobes.focusStart;
      balanceStartPulse <= strobes.balStart;
      if (strobes.rst) begin
        laserOn      <= 1'b0;
        focusServoOn <= 1'b0;
        spindleMode  <= SPIN_OFF;
        sledOn       <= 1'b0;
        trackServoOn <= 1'b0;
      end else begin
        if (strobes.servoWr) begin
          laserOn      <= strobes.laserVal;
          focusServoOn <= strobes.focServoVal;
        end
        if (strobes.spinWr) spindleMode  <= strobes.spinVal;
        if (strobes.sledWr) sledOn       <= strobes.sledVal;
        if (strobes.trkWr)  trackServoOn <= strobes.trkVal;
      end
    end
  end

  for (genvar ch = 0; ch < N_ADJ; ch++) begin : g_adj
    logic [CNT_W-1:0] holdCnt;
    logic             waitStart;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt           <= CNT_W'(HOLD_TICKS);
        waitStart         <= 1'b0;
        adjActive[ch]     <= 1'b0;
        adjStartPulse[ch] <= 1'b0;
        adjStopPulse[ch]  <= 1'b0;
      end else begin
        adjStartPulse[ch] <= 1'b0;
        adjStopPulse[ch]  <= 1'b0;
        if (strobes.rst) begin
          holdCnt       <= CNT_W'(HOLD_TICKS);
          waitStart     <= 1'b0;
          adjActive[ch] <= 1'b0;
        end else if (stopReq[ch]) begin
          holdCnt          <= CNT_W'(HOLD_TICKS);
          waitStart        <= 1'b0;
          adjActive[ch]    <= 1'b0;
          adjStopPulse[ch] <= 1'b1;
        end else begin
          if (tick && holdCnt != '0) holdCnt <= holdCnt - CNT_W'(1);
          if (startReq[ch]) begin
            if (holdCnt == '0) begin
              adjActive[ch]     <= 1'b1;
              adjStartPulse[ch] <= 1'b1;
            end else begin
              waitStart <= 1'b1;
            end
          end else if (waitStart && holdCnt == '0) begin
            waitStart         <= 1'b0;
            adjActive[ch]     <= 1'b1;
            adjStartPulse[ch] <= 1'b1;
          end
        end
      end
    end

    // R12: an adjustment never begins while its hold-off is still counting
    assert_holdoff_R12: assert property (@(posedge clk) disable iff (!rstN)
      adjStartPulse[ch] |-> holdCnt == '0);

    // R11: a start strobe lasts one cycle
    assert_start_width_R11: assert property (@(posedge clk) disable iff (!rstN)
      adjStartPulse[ch] |=> !adjStartPulse[ch]);
  end

  // R9: reset command leaves every mode cleared
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rst |=> (!laserOn && !focusServoOn && spindleMode == SPIN_OFF &&
                     !sledOn && !trackServoOn && adjActive == '0));

  // R7: strobes are single-cycle
  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (focusSearchPulse || balanceStartPulse) |=> !(focusSearchPulse || balanceStartPulse));

  // R10: the laser mode moves only on a servo write or a reset command
  assert_laser_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(laserOn) |-> $past(strobes.servoWr || strobes.rst));
endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
  import cmdrx_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 520
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       serClk,
  input  logic       serData,
  input  logic       refClk,
  output logic       laserOn,
  output logic       focusServoOn,
  output logic [1:0] spindleMode,
  output logic       sledOn,
  output logic       trackServoOn,
  output logic       focusAdjActive,
  output logic       trackAdjActive,
  output logic       resetPulse,
  output logic       focusSearchPulse,
  output logic       balanceStartPulse,
  output logic       focusAdjStartPulse,
  output logic       focusAdjStopPulse,
  output logic       trackAdjStartPulse,
  output logic       trackAdjStopPulse
);
  cmdStrobes_t strobes;
  logic        tick;
  spindle_e    spinState;
  logic [1:0]  adjActive, adjStartPulse, adjStopPulse;

  cmdrx_ctrl #(.CMD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .serEn(serEn), .serClk(serClk), .serData(serData), .refClk(refClk),
    .strobes(strobes), .tick(tick)
  );

  cmdrx_datapath #(.HOLD_TICKS(HOLD_TICKS)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .tick(tick),
    .laserOn(laserOn), .focusServoOn(focusServoOn), .spindleMode(spinState),
    .sledOn(sledOn), .trackServoOn(trackServoOn),
    .adjActive(adjActive), .adjStartPulse(adjStartPulse), .adjStopPulse(adjStopPulse),
    .resetPulse(resetPulse), .focusSearchPulse(focusSearchPulse),
    .balanceStartPulse(balanceStartPulse)
  );

  assign spindleMode        = spinState;
  assign focusAdjActive     = adjActive[0];
  assign trackAdjActive     = adjActive[1];
  assign focusAdjStartPulse = adjStartPulse[0];
  assign trackAdjStartPulse = adjStartPulse[1];
  assign focusAdjStopPulse  = adjStopPulse[0];
  assign trackAdjStopPulse  = adjStopPulse[1];
endmodule

// File: tb/tb_ser_cmd_rx.sv
module tb_ser_cmd_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0, serClk = 1'b0, serData = 1'b0, refClk = 1'b0;
  logic laserOn, focusServoOn, sledOn, trackServoOn;
  logic [1:0] spindleMode;
  logic focusAdjActive, trackAdjActive;
  logic resetPulse, focusSearchPulse, balanceStartPulse;
  logic focusAdjStartPulse, focusAdjStopPulse, trackAdjStartPulse, trackAdjStopPulse;

  int total = 0;
  int bad = 0;
  int cntReset = 0, cntFocus = 0, cntBal = 0;
  int cntFaS = 0, cntFaO = 0, cntTaS = 0, cntTaO = 0;
  int wideErr = 0;
  logic [6:0] prevPulses = '0;

  always #10 clk = ~clk;  // 50 MHz

  ser_cmd_rx #(.CMD_W(8), .SYNC_STAGES(2), .HOLD_TICKS(4)) dut (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(serData),
    .refClk(refClk), .laserOn(laserOn), .focusServoOn(focusServoOn),
    .spindleMode(spindleMode), .sledOn(sledOn), .trackServoOn(trackServoOn),
    .focusAdjActive(focusAdjActive), .trackAdjActive(trackAdjActive),
    .resetPulse(resetPulse), .focusSearchPulse(focusSearchPulse),
    .balanceStartPulse(balanceStartPulse), .focusAdjStartPulse(focusAdjStartPulse),
    .focusAdjStopPulse(focusAdjStopPulse), .trackAdjStartPulse(trackAdjStartPulse),
    .trackAdjStopPulse(trackAdjStopPulse)
  );

  // strobe monitors
  always @(posedge clk) begin
    logic [6:0] cur;
    cur = {resetPulse, focusSearchPulse, balanceStartPulse, focusAdjStartPulse,
           focusAdjStopPulse, trackAdjStartPulse, trackAdjStopPulse};
    if (rstN) begin
      if (cur[6]) cntReset++;
      if (cur[5]) cntFocus++;
      if (cur[4]) cntBal++;
      if (cur[3]) cntFaS++;
      if (cur[2]) cntFaO++;
      if (cur[1]) cntTaS++;
      if (cur[0]) cntTaO++;
      if ((cur & prevPulses) != '0) wideErr++;
    end
    prevPulses = cur;
  end

  // {cmd, laser, focusServo, spindle[1:0], sled, track}
  localparam int NVEC = 12;
  localparam logic [13:0] VEC [NVEC] = '{
    {8'h06, 6'b110000}, {8'h09, 6'b110100}, {8'h0C, 6'b110110}, {8'h10, 6'b110111},
    {8'h0A, 6'b111011}, {8'h55, 6'b111011}, {8'h07, 6'b011011}, {8'h0F, 6'b011010},
    {8'h0D, 6'b011000}, {8'h0B, 6'b010000}, {8'h08, 6'b000000}, {8'hFE, 6'b000000}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [15:0] val, input int nbits);
    serEn = 1'b1;
    waitClk(4);
    for (int b = 0; b < nbits; b++) begin
      serData = val[b];
      waitClk(3);
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
      waitClk(3);
    end
    waitClk(3);
    serEn = 1'b0;
    waitClk(6);
  endtask

  task automatic refTick();
    refClk = 1'b1;
    waitClk(6);
    refClk = 1'b0;
    waitClk(6);
  endtask

  task automatic sendCmd(input logic [7:0] code);
    sendBits({8'h00, code}, 8);
    refTick();
  endtask

  task automatic barePulse();
    serEn = 1'b1;
    waitClk(6);
    serEn = 1'b0;
    waitClk(6);
    refTick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1: reset state
    check("R1 laser", laserOn, 0);
    check("R1 focus servo", focusServoOn, 0);
    check("R1 spindle", spindleMode, 0);
    check("R1 sled/track", {sledOn, trackServoOn}, 0);
    check("R1 adjust", {focusAdjActive, trackAdjActive}, 0);
    check("R1 strobes", cntReset + cntFocus + cntBal + cntFaS + cntFaO + cntTaS + cntTaO, 0);

    repeat (5) refTick();  // let power-on hold-off run out

    // R4 R5 R6 R10: table of level commands
    for (int i = 0; i < NVEC; i++) begin
      sendCmd(VEC[i][13:6]);
      check($sformatf("R4 row %0d laser", i), laserOn, VEC[i][5]);
      check($sformatf("R4 row %0d focus servo", i), focusServoOn, VEC[i][4]);
      check($sformatf("R5 row %0d spindle", i), spindleMode, VEC[i][3:2]);
      check($sformatf("R6 row %0d sled", i), sledOn, VEC[i][1]);
      check($sformatf("R6 row %0d track", i), trackServoOn, VEC[i][0]);
    end

    // R3: nothing before the reference tick
    sendBits(16'h0006, 8);
    waitClk(20);
    check("R3 before tick", laserOn, 0);
    refTick();
    check("R3 after tick", laserOn, 1);
    sendCmd(8'h08);

    // R2: LSB first, ten bits keep the last eight (0x0C sled on)
    sendBits(16'h0033, 10);
    refTick();
    check("R2 ten-bit transfer", sledOn, 1);
    sendCmd(8'h0D);
    check("R2 sled off", sledOn, 0);

    // R7 R8 R13: strobe, replay, idle shift clocks
    base = cntFocus;
    sendCmd(8'h01);
    check("R7 focus search strobe", cntFocus, base + 1);
    serData = 1'b0;
    for (int k = 0; k < 8; k++) begin
      serClk = 1'b1; waitClk(4); serClk = 1'b0; waitClk(4);
    end
    barePulse();
    check("R8 replay of held command", cntFocus, base + 2);
    check("R13 idle clocks ignored", cntReset, 0);
    sendCmd(8'hFE);
    barePulse();
    check("R8 no-op stops replay", cntFocus, base + 2);

    base = cntBal;
    sendCmd(8'h0E);
    check("R7 balance strobe", cntBal, base + 1);

    // R9: reset command
    sendCmd(8'h06);
    sendCmd(8'h0C);
    sendCmd(8'h00);
    check("R9 laser cleared", laserOn, 0);
    check("R9 sled cleared", sledOn, 0);
    check("R9 reset strobe", cntReset, 1);

    // R12: deferred focus adjustment start
    base = cntFaS;
    sendCmd(8'h02);
    refTick();
    refTick();
    check("R12 still held off", focusAdjActive, 0);
    check("R12 no early strobe", cntFaS, base);
    refTick();
    check("R12 released", focusAdjActive, 1);
    check("R12 start strobe", cntFaS, base + 1);

    // R11: stop and immediate track adjustment
    sendCmd(8'h03);
    check("R11 focus stop", focusAdjActive, 0);
    check("R11 focus stop strobe", cntFaO, 1);
    repeat (5) refTick();
    sendCmd(8'h04);
    check("R11 track start", trackAdjActive, 1);
    check("R11 track start strobe", cntTaS, 1);
    sendCmd(8'h05);
    check("R11 track stop", trackAdjActive, 0);
    check("R11 track stop strobe", cntTaO, 1);

    check("R7 strobe width", wideErr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule